// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block models a small fuse-configured logic device. A programmable AND plane builds 64 product terms. Each term draws on 16 signals, and each signal is offered in true and complement form. A fixed OR plane then sums 8 terms into each of 8 output macrocells. Each macrocell can pass its sum straight to its pin or capture it in a register. It can invert the result and pick one of four output-enable sources. The value of every macrocell returns to the AND plane as feedback. A pin whose driver is off therefore works as an extra input.

The fuse map holds 2080 bits and is loaded serially. While `cfg_load` is high, one bit enters on each clock, most significant bit first. The map takes effect on the clock edge after `cfg_load` falls, and only if exactly 2080 bits were shifted. Two of the ten dedicated inputs have fixed roles and never reach the AND plane. `in_pins[0]` enables the macrocell registers. `in_pins[9]` is the shared output enable and is active low. The eight pins in between, `in_pins[8:1]`, are AND-plane signals 0 to 7.

Top module: `pal_array`

## Requirements
- R1: Reset clears the loaded-map flag and every macrocell register. From reset until a complete load, `io_oe` is all zero, and the first registered output after a load reads 0.
- R2: Loading shifts `cfg_bit` in MSB first, bit 2079 first, while `cfg_load` is high. `io_oe` is zero throughout the load. A load of any length other than 2080 bits leaves `io_oe` at zero.
- R3: Signal s is column 2s in true form and column 2s+1 in complement form. Signals 0 to 7 are `in_pins[1..8]`, and signal 8+k is the feedback of output k. Term p uses fuse bits p*32 to p*32+31, and a bit set to 1 connects its literal. A term is the AND of its connected literals, so a term with no connections is 1 and a term with all 32 connected is 0.
- R4: Output k ORs terms 8k to 8k+7. When its enable mode is 3, it ORs only terms 8k+1 to 8k+7.
- R5: Option bits for output k sit at 2048+4k. Bit +1 is polarity, and a value of 1 inverts the value on `io_out[k]`.
- R6: Option bit +0 set to 0 selects combinational mode. In that mode `io_out[k]` follows the inputs in the same cycle, and the feedback of output k is `io_in[k]`.
- R7: Option bit +0 set to 1 selects registered mode. The register captures the sum on a rising `clk` edge when `in_pins[0]` is 1 and holds its value otherwise. Its feedback is the register value before polarity.
- R8: Option bits +3:+2 set the enable mode. Mode 0 is off and mode 1 is on. Mode 2 enables the output while `in_pins[9]` is 0. Mode 3 enables it while term 8k is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading and for the macrocell registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | High while the fuse map is being shifted in |
| cfg_bit | input | 1 | Serial fuse data, MSB first |
| in_pins | input | 10 | Dedicated inputs; bit 0 enables the registers, bit 9 is the shared output enable (active low) |
| io_in | input | 8 | Value seen on each bidirectional pin |
| io_out | output | 8 | Value each macrocell drives |
| io_oe | output | 8 | Output enable for each bidirectional pin |

## Verification
Combinational outputs and output enables settle in the same cycle as their inputs. The bench changes inputs on the falling edge and samples 1 ns later, before the next rising edge. A registered output changes on the first rising edge at which the register enable is high, so the bench checks it on the falling edge that follows. A new fuse map takes effect at the rising edge after `cfg_load` drops, and the bench samples it on the falling edge after that edge.

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN  = 10,
  parameter int N_IO  = 8,
  parameter int TERMS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_bit,
  input  logic [N_IN-1:0] in_pins,
  input  logic [N_IO-1:0] io_in,
  output logic [N_IO-1:0] io_out,
  output logic [N_IO-1:0] io_oe
);
  localparam int IN_SIG    = N_IN - 2;
  localparam int N_SIG     = IN_SIG + N_IO;
  localparam int N_COL     = 2 * N_SIG;
  localparam int N_TERM    = N_IO * TERMS;
  localparam int AND_BITS  = N_COL * N_TERM;
  localparam int FUSE_BITS = AND_BITS + 4 * N_IO;
  localparam int CNT_W     = $clog2(FUSE_BITS + 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FUSE_BITS);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(FUSE_BITS + 1);

  logic [FUSE_BITS-1:0] fuse;
  logic [CNT_W-1:0]     cnt;
  logic                 load_q;
  logic                 cfg_valid;
  logic [N_IO-1:0]      mc_q;
  logic [N_IO-1:0]      sum;
  logic [N_SIG-1:0]     sig;
  logic [N_COL-1:0]     lit;
  logic [N_TERM-1:0]    term;

  always_ff @(posedge clk)
    if (cfg_load) fuse <= {fuse[FUSE_BITS-2:0], cfg_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      load_q    <= 1'b0;
      cfg_valid <= 1'b0;
    end else begin
      load_q <= cfg_load;
      if (cfg_load) begin
        cfg_valid <= 1'b0;
        if (!load_q)              cnt <= CNT_W'(1);
        else if (cnt != SAT_CNT)  cnt <= cnt + 1'b1;
      end else if (load_q) begin
        cfg_valid <= (cnt == FULL_CNT);
      end
    end
  end

  assign sig[IN_SIG-1:0] = in_pins[N_IN-2:1];

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig[s];
    assign lit[2*s+1] = ~sig[s];
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    assign term[p] = &(~fuse[p*N_COL +: N_COL] | lit);
  end

  for (genvar o = 0; o < N_IO; o++) begin : g_mc
    logic [3:0]       opt;
    logic [TERMS-1:0] grp;
    logic             oe_raw;
    assign opt = fuse[AND_BITS + 4*o +: 4];
    assign grp = term[o*TERMS +: TERMS];
    assign sum[o] = (opt[3:2] == 2'b11) ? |grp[TERMS-1:1] : |grp;
    assign sig[IN_SIG + o] = opt[0] ? mc_q[o] : io_in[o];
    assign io_out[o] = (opt[0] ? mc_q[o] : sum[o]) ^ opt[1];
    assign oe_raw = (opt[3:2] == 2'b01)
                  | ((opt[3:2] == 2'b10) & ~in_pins[N_IN-1])
                  | ((opt[3:2] == 2'b11) & grp[0]);
    assign io_oe[o] = cfg_valid & ~cfg_load & oe_raw;

    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (opt[3:2] == 2'b00) |-> !io_oe[o]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    mc_q <= '0;
    else if (cfg_valid && in_pins[0]) mc_q <= sum;

  p_quiet_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (io_oe == '0));

  p_load_drops_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !cfg_valid);

  p_fuse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(fuse));

  p_reg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_pins[0] |=> $stable(mc_q));

  p_reg_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && in_pins[0]) |=> (mc_q == $past(sum)));
endmodule

// File: tb/pal_array_tb.sv
`timescale 1ns/1ps
module pal_array_tb;
  localparam int FUSE = 2080;
  localparam int NV   = 8;
  // {in_pins, io_in, expected io_out, expected io_oe}
  localparam logic [33:0] VEC [NV] = '{
    {10'h000, 8'h00, 8'h06, 8'hB7},
    {10'h006, 8'h00, 8'h07, 8'hB7},
    {10'h010, 8'h08, 8'h07, 8'hB7},
    {10'h01A, 8'h08, 8'h16, 8'hB7},
    {10'h2A0, 8'h00, 8'h24, 8'h97},
    {10'h100, 8'h00, 8'h06, 8'hF7},
    {10'h140, 8'h08, 8'h46, 8'hF7},
    {10'h3FE, 8'h08, 8'h75, 8'hD7}
  };

  logic clk = 0, rst_n = 0, cfg_load = 0, cfg_bit = 0;
  logic [9:0] in_pins = '0;
  logic [7:0] io_in = '0;
  logic [7:0] io_out, io_oe;
  logic [FUSE-1:0] cfg;
  int checks = 0, failures = 0;
  bit done = 0;

  pal_array u_dut (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
                   .in_pins(in_pins), .io_in(io_in), .io_out(io_out), .io_oe(io_oe));

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_term(int p);
    cfg[p*32 +: 32] = '0;
  endtask

  task automatic connect(int p, int s, int comp);
    cfg[p*32 + 2*s + comp] = 1'b1;
  endtask

  task automatic load(int nbits, bit mid_check);
    for (int i = FUSE - 1; i >= FUSE - nbits; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_bit  = cfg[i];
      if (mid_check && i == FUSE - 10) begin
        #1 check("R2 enables off during load", io_oe, 8'h00);
      end
    end
    @(negedge clk);
    cfg_load = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    cfg = '1;
    clear_term(0);  connect(0, 0, 0);  connect(0, 1, 0);
    clear_term(1);  connect(1, 2, 1);  connect(1, 3, 0);
    clear_term(8);  connect(8, 4, 0);
    clear_term(16);
    clear_term(32); connect(32, 11, 0); connect(32, 0, 0);
    clear_term(40); connect(40, 6, 0);
    clear_term(48); connect(48, 7, 0);
    clear_term(49); connect(49, 5, 0);
    clear_term(56); connect(56, 15, 1);
    cfg[2048 +: 32] = {4'b0101, 4'b1100, 4'b1000, 4'b0100,
                       4'b0000, 4'b0100, 4'b0110, 4'b0100};

    repeat (3) @(negedge clk);
    #1 check("R1 enables off in reset", io_oe, 8'h00);
    rst_n = 1'b1;

    load(FUSE - 1, 1'b0);
    check("R2 short load keeps enables off", io_oe, 8'h00);

    load(FUSE, 1'b0);
    check("R2 full load enables outputs", io_oe, 8'hB7);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_pins = VEC[i][33:24];
      io_in   = VEC[i][23:16];
      #1;
      check($sformatf("R3 R4 R5 R6 outputs vector %0d", i), io_out, VEC[i][15:8]);
      check($sformatf("R8 enables vector %0d", i), io_oe, VEC[i][7:0]);
    end

    @(negedge clk); in_pins = 10'h000; io_in = 8'h00;
    #1 check("R1 register cleared", {7'd0, io_out[7]}, 8'h00);
    @(negedge clk); in_pins = 10'h001;
    @(negedge clk); in_pins = 10'h000;
    #1 check("R7 capture on enabled edge", {7'd0, io_out[7]}, 8'h01);
    repeat (3) @(negedge clk);
    #1 check("R7 hold without enable", {7'd0, io_out[7]}, 8'h01);
    @(negedge clk); in_pins = 10'h001;
    @(negedge clk); in_pins = 10'h000;
    #1 check("R7 feedback toggles to 0", {7'd0, io_out[7]}, 8'h00);
    @(negedge clk); in_pins = 10'h001;
    @(negedge clk); in_pins = 10'h000;
    #1 check("R7 feedback toggles to 1", {7'd0, io_out[7]}, 8'h01);

    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 reset disables outputs", io_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    load(FUSE, 1'b1);
    check("R1 register zero after reload", {7'd0, io_out[7]}, 8'h00);
    check("R2 reload enables outputs", io_oe, 8'hB7);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule